// File: doc/BRIEF.md
# System Control Register Bank

This block gives a processor subsystem a 4 KB window of general-purpose control words, reached over a simple synchronous register bus: select, write enable, byte address, write data, read data and ready. Behind the window sit 512 words of 32 bits. The word index is taken from the byte address with its two low bits dropped. The upper 2 KB of the window aliases the lower 2 KB, so byte offsets 0x000 and 0x800 land on the same word.

Four words leave reset with fixed identification contents. Three of them always read back with bits 29:28 set, and the stored value stays as it was. The command decode works on the full byte offset. A write of a specific value to offset 0xF00 raises a one-cycle request to the system reset controller or to the power controller. That write is still stored like any other, so it can be read back afterwards.

Every cycle in which select is high is one access. Ready and, for a read, the read data follow one cycle later.

Top module: `sysctl_regbank`

## Requirements
- R1: While reset is high and in the first cycle after it, ready, both request outputs and the read data are 0. Every word other than the four identification words reads 0 after reset.
- R2: After reset, offset 0x100 reads 0x35F20121, 0x104 reads 0x00000002, 0x108 reads 0x35F30121 and 0x10C reads 0x35F40121. These are the stored 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121, with forcing applied.
- R3: A write stores its data in the word selected by address bits 10:2. Address bits 1:0 are ignored and bit 11 only selects an alias, so a read of the same word returns the data.
- R4: For each cycle with select high, ready is 1 in the next cycle. For a read, the read data is valid in that same next cycle. Ready is 0 after a cycle with select low.
- R5: A write of 1 or 2 to byte offset 0xF00 sets the reset request output to 1 for exactly the cycle after the write.
- R6: A write of 3 to byte offset 0xF00 sets the shutdown request output to 1 for exactly the cycle after the write.
- R7: A write of any other value to offset 0xF00 raises no request. In every case the value written to 0xF00 is stored and reads back unchanged.
- R8: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000, and the stored word itself is not altered. Reads of the same words through the alias offsets 0x900, 0x908 and 0x90C return the stored word unforced, and so does offset 0x104.
- R9: The two request outputs are never 1 in the same cycle. If both commands could match, reset wins.
- R10: Writes to any offset other than 0xF00, including its alias 0x700, raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Access strobe, one access per cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with ready after a read |
| ready | output | 1 | Access completion, one cycle after select |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
The bench works through the command values around the decode boundaries: 0, 1, 2, 3, 4 and all-ones. A decoder that compared too few data bits would pulse on 0x101 or all-ones, and one that ran on the word index alone would fire on the alias 0x700. Reading the forced words through their unforced alias after writing zero shows whether the forcing leaked into storage: a design that wrote forced bits back would return 0x30000000 there. The identification reset values and the ignored low address bits are checked by readback, which catches a swapped word order or a misdecoded index.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned SC_ADDR_W    = 12;
    localparam int unsigned SC_DATA_W    = 32;
    localparam int unsigned SC_NUM_WORDS = 512;

    // Byte offsets that carry behaviour
    localparam logic [SC_ADDR_W-1:0] SC_CMD_OFS  = 12'hF00;
    localparam logic [SC_ADDR_W-1:0] SC_ID0_OFS  = 12'h100;
    localparam logic [SC_ADDR_W-1:0] SC_ID1_OFS  = 12'h104;
    localparam logic [SC_ADDR_W-1:0] SC_ID2_OFS  = 12'h108;
    localparam logic [SC_ADDR_W-1:0] SC_ID3_OFS  = 12'h10C;

    localparam logic [SC_DATA_W-1:0] SC_FORCE_MASK = 32'h3000_0000;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_SHUTDOWN = 2'd2
    } sc_cmd_e;

    typedef struct packed {
        logic                   rd_fire;
        logic                   wr_fire;
        logic [SC_ADDR_W-3:0]   word_addr;
        logic [SC_DATA_W-1:0]   data;
    } sc_access_t;

    // Reset contents of a storage word, by word index
    function automatic logic [SC_DATA_W-1:0] word_reset_value(input int unsigned idx);
        logic [SC_DATA_W-1:0] v;
        v = '0;
        if (idx == int'(SC_ID0_OFS >> 2)) v = 32'h05F2_0121;
        if (idx == int'(SC_ID1_OFS >> 2)) v = 32'h0000_0002;
        if (idx == int'(SC_ID2_OFS >> 2)) v = 32'h05F3_0121;
        if (idx == int'(SC_ID3_OFS >> 2)) v = 32'h05F4_0121;
        return v;
    endfunction

    // Words whose reads get the status bits forced, by full word address
    function automatic logic is_forced_word(input logic [SC_ADDR_W-3:0] wa);
        return (wa == SC_ID0_OFS[SC_ADDR_W-1:2]) ||
               (wa == SC_ID2_OFS[SC_ADDR_W-1:2]) ||
               (wa == SC_ID3_OFS[SC_ADDR_W-1:2]);
    endfunction

    // Command value decode; reset has priority over shutdown
    function automatic sc_cmd_e decode_cmd(input logic [SC_DATA_W-1:0] v);
        sc_cmd_e c;
        c = CMD_NONE;
        if (v == 32'd1 || v == 32'd2) c = CMD_RESET;
        else if (v == 32'd3)          c = CMD_SHUTDOWN;
        return c;
    endfunction

endpackage

// File: rtl/sysctl_reg_store.sv
module sysctl_reg_store
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_WORDS = SC_NUM_WORDS,
    parameter int unsigned DATA_W    = SC_DATA_W,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] words [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                words[w] <= DATA_W'(word_reset_value(w));
            end
        end else if (we) begin
            words[idx] <= wdata;
        end
    end

    assign rd_word = words[idx];

    // Checker state: last write, to confirm it landed
    logic              chk_we_q;
    logic [IDX_W-1:0]  chk_idx_q;
    logic [DATA_W-1:0] chk_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_we_q   <= 1'b0;
            chk_idx_q  <= '0;
            chk_data_q <= '0;
        end else begin
            chk_we_q   <= we;
            chk_idx_q  <= idx;
            chk_data_q <= wdata;
        end
    end

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        chk_we_q |-> (words[chk_idx_q] == chk_data_q));

endmodule

// File: rtl/sysctl_cmd_decode.sv
module sysctl_cmd_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = SC_ADDR_W,
    parameter int unsigned DATA_W = SC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [ADDR_W-3:0] word_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              reset_req,
    output logic              shutdown_req
);

    localparam logic [ADDR_W-3:0] CMD_WA = SC_CMD_OFS[ADDR_W-1:2];

    logic    hit;
    sc_cmd_e cmd;

    assign hit = wr_fire && (word_addr == CMD_WA);
    assign cmd = hit ? decode_cmd(SC_DATA_W'(wdata)) : CMD_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_req    <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            reset_req    <= (cmd == CMD_RESET);
            shutdown_req <= (cmd == CMD_SHUTDOWN);
        end
    end

    // R9
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reset_req, shutdown_req}));

    // R5
    reset_src_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(wr_fire && word_addr == CMD_WA));

    // R6
    shutdown_src_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(wr_fire && word_addr == CMD_WA && wdata == DATA_W'(3)));

    // R10
    no_req_elsewhere_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && word_addr != CMD_WA) |=> !(reset_req || shutdown_req));

endmodule

// File: rtl/sysctl_read_path.sv
module sysctl_read_path
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = SC_ADDR_W,
    parameter int unsigned DATA_W = SC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rd_fire,
    input  logic [ADDR_W-3:0] word_addr,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);

    localparam logic [DATA_W-1:0] MASK = DATA_W'(SC_FORCE_MASK);

    logic [DATA_W-1:0] shaped;

    assign shaped = is_forced_word(SC_ADDR_W'(word_addr) >> 0 == 0 ? '0 : word_addr)
                    ? (stored | MASK) : stored;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            ready <= 1'b0;
        end else begin
            ready <= sel;
            if (rd_fire) rdata <= shaped;
        end
    end

    // R4
    ready_follows_sel_chk: assert property (@(posedge clk) disable iff (rst)
        sel |=> ready);

    // R4
    ready_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !ready);

    // R8
    forced_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && is_forced_word(word_addr)) |=> (rdata[29:28] == 2'b11));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = SC_ADDR_W,
    parameter int unsigned DATA_W    = SC_DATA_W,
    parameter int unsigned NUM_WORDS = SC_NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              sys_reset_req,
    output logic              sys_shutdown_req
);

    localparam int unsigned IDX_W = $clog2(NUM_WORDS);

    sc_access_t        acc;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] stored;

    always_comb begin
        acc.rd_fire   = sel && !wr_en;
        acc.wr_fire   = sel && wr_en;
        acc.word_addr = (SC_ADDR_W-2)'(addr[ADDR_W-1:2]);
        acc.data      = SC_DATA_W'(wdata);
    end

    assign idx = acc.word_addr[IDX_W-1:0];

    sysctl_reg_store #(
        .NUM_WORDS (NUM_WORDS),
        .DATA_W    (DATA_W)
    ) store_i (
        .clk     (clk),
        .rst     (rst),
        .we      (acc.wr_fire),
        .idx     (idx),
        .wdata   (wdata),
        .rd_word (stored)
    );

    sysctl_cmd_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) cmd_i (
        .clk          (clk),
        .rst          (rst),
        .wr_fire      (acc.wr_fire),
        .word_addr    (addr[ADDR_W-1:2]),
        .wdata        (wdata),
        .reset_req    (sys_reset_req),
        .shutdown_req (sys_shutdown_req)
    );

    sysctl_read_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) rd_i (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .rd_fire   (acc.rd_fire),
        .word_addr (addr[ADDR_W-1:2]),
        .stored    (stored),
        .rdata     (rdata),
        .ready     (ready)
    );

endmodule

// File: tb/sysctl_regbank_tb_top.sv
`timescale 1ns/1ps
module sysctl_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel;
    logic        wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        ready;
    logic        sys_reset_req;
    logic        sys_shutdown_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_regbank dut_i (
        .clk              (clk),
        .rst              (rst),
        .sel              (sel),
        .wr_en            (wr_en),
        .addr             (addr),
        .wdata            (wdata),
        .rdata            (rdata),
        .ready            (ready),
        .sys_reset_req    (sys_reset_req),
        .sys_shutdown_req (sys_shutdown_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue a write; return the outputs seen in the cycle after it
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             output logic rdy, output logic rq, output logic sq);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        rdy = ready; rq = sys_reset_req; sq = sys_shutdown_req;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic rdy);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = a;
        @(posedge clk); #1;
        d = rdata; rdy = ready;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic r;
        check("R1 ready", {31'd0, ready}, 32'd0);
        check("R1 reset_req", {31'd0, sys_reset_req}, 32'd0);
        check("R1 shutdown_req", {31'd0, sys_shutdown_req}, 32'd0);
        check("R1 rdata", rdata, 32'd0);
        bus_read(12'h000, d, r); check("R1 word 0x000", d, 32'd0);
        bus_read(12'h7FC, d, r); check("R1 word 0x7FC", d, 32'd0);
        bus_read(12'hF00, d, r); check("R1 word 0xF00", d, 32'd0);
    endtask

    task automatic t_ids();
        logic [31:0] d; logic r;
        bus_read(12'h100, d, r); check("R2 0x100", d, 32'h35F2_0121);
        bus_read(12'h104, d, r); check("R2 0x104", d, 32'h0000_0002);
        bus_read(12'h108, d, r); check("R2 0x108", d, 32'h35F3_0121);
        bus_read(12'h10C, d, r); check("R2 0x10C", d, 32'h35F4_0121);
    endtask

    task automatic t_readwrite();
        logic [31:0] d; logic r, rq, sq;
        bus_write(12'h004, 32'hA5A5_5A5A, r, rq, sq);
        check("R4 write ready", {31'd0, r}, 32'd1);
        check("R10 write 0x004 no req", {30'd0, rq, sq}, 32'd0);
        bus_read(12'h004, d, r);
        check("R3 readback 0x004", d, 32'hA5A5_5A5A);
        check("R4 read ready", {31'd0, r}, 32'd1);
        @(posedge clk); #1;
        check("R4 ready drops", {31'd0, ready}, 32'd0);
        bus_write(12'h00B, 32'h1234_5678, r, rq, sq);
        bus_read(12'h008, d, r);
        check("R3 low bits ignored", d, 32'h1234_5678);
        bus_read(12'h808, d, r);
        check("R3 upper alias", d, 32'h1234_5678);
    endtask

    task automatic cmd_case(input logic [31:0] v, input logic exp_r, input logic exp_s);
        logic [31:0] d; logic r, rq, sq;
        bus_write(12'hF00, v, r, rq, sq);
        check(exp_r ? "R5 reset pulse" : "R7 no reset pulse", {31'd0, rq}, {31'd0, exp_r});
        check(exp_s ? "R6 shutdown pulse" : "R7 no shutdown pulse", {31'd0, sq}, {31'd0, exp_s});
        check("R9 exclusive", {31'd0, rq & sq}, 32'd0);
        @(posedge clk); #1;
        check("R5 R6 single cycle", {30'd0, sys_reset_req, sys_shutdown_req}, 32'd0);
        bus_read(12'hF00, d, r);
        check("R7 command word stored", d, v);
    endtask

    task automatic t_commands();
        cmd_case(32'd1, 1'b1, 1'b0);
        cmd_case(32'd2, 1'b1, 1'b0);
        cmd_case(32'd3, 1'b0, 1'b1);
        cmd_case(32'd0, 1'b0, 1'b0);
        cmd_case(32'd4, 1'b0, 1'b0);
        cmd_case(32'h0000_0101, 1'b0, 1'b0);
        cmd_case(32'hFFFF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_forcing();
        logic [31:0] d; logic r, rq, sq;
        bus_write(12'h108, 32'd0, r, rq, sq);
        bus_read(12'h108, d, r); check("R8 forced 0x108", d, 32'h3000_0000);
        bus_read(12'h908, d, r); check("R8 storage unforced 0x908", d, 32'h0000_0000);
        bus_write(12'h10C, 32'h0000_000F, r, rq, sq);
        bus_read(12'h10C, d, r); check("R8 forced 0x10C", d, 32'h3000_000F);
        bus_write(12'h104, 32'd1, r, rq, sq);
        bus_read(12'h104, d, r); check("R8 0x104 not forced", d, 32'h0000_0001);
        bus_read(12'h900, d, r); check("R8 alias 0x900 unforced", d, 32'h05F2_0121);
    endtask

    task automatic t_alias_cmd();
        logic [31:0] d; logic r, rq, sq;
        bus_write(12'h700, 32'd1, r, rq, sq);
        check("R10 alias 0x700 no req", {30'd0, rq, sq}, 32'd0);
        bus_read(12'hF00, d, r);
        check("R3 alias 0x700 stores", d, 32'd1);
    endtask

    initial begin
        rst = 1'b1; sel = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (4) @(posedge clk);
        #1;
        check("R1 ready in reset", {31'd0, ready}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_ids();
        t_readwrite();
        t_commands();
        t_forcing();
        t_alias_cmd();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule